// File: doc/BRIEF.md
# Frame Phase Meter

This block measures where a recovered 8 kHz clock edge lands inside the local serial-bus frame of 32 channels of 8 bits each. It counts channels and bits from the local frame pulse on every cycle of the bit clock. On each rising edge of the 8 kHz input it stores the current channel and bit count as a phase reading. A clock-steering loop outside this block uses the reading to keep the receive elastic buffer centred. The loop must hold the phase within about 26 channels peak-to-peak so that the buffer never slips.

A ninth bit, the wrap bit, extends the reading past one frame. Two successive readings that differ by more than half a frame are taken as a crossing of the frame boundary, and the wrap bit then toggles. This lets the host follow drift that adds up to more than one frame in either direction.

The 8 kHz input is asynchronous to the bit clock. It passes through a two-flop synchroniser before its rising edge is detected.

Top module: `frame_phase_meter`

## Requirements
- R1: A position counter advances by one on every bit clock. Its upper 5 bits are the channel (0..31) and its lower 3 bits are the bit within the channel (0..7). It rolls over from channel 31 bit 7 to channel 0 bit 0.
- R2: When frame pulse is high at a clock edge, the position counter is loaded with 0 at that edge. This realigns it to channel 0, bit 0 whatever its previous value.
- R3: The 8 kHz input passes through two synchronising flops. Suppose it is first sampled high at edge k after being sampled low at edge k-1. Then at edge k+2, phaseWord[7:0] takes the counter value held between edges k+1 and k+2, laid out as {channel, bit}.
- R4: Between captures, phaseWord holds its value. A falling edge of the 8 kHz input, or the input staying at a constant level, changes nothing.
- R5: At a capture, phaseWord[8] toggles if the new reading is smaller than the previous one by more than 128 (half a frame). This is a forward crossing past channel 31 bit 7.
- R6: At a capture, phaseWord[8] toggles if the new reading is larger than the previous one by more than 128. This is a backward crossing below channel 0 bit 0.
- R7: phaseWord[8] does not change when two successive readings differ by 128 or less. It also does not change at the first capture after reset.
- R8: An active-low asynchronous reset clears phaseWord to 0, clears the position counter and the synchroniser, and forgets any previous reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-bus bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | Local frame start; realigns the counter to channel 0 bit 0 |
| refClk8k | input | 1 | Recovered 8 kHz clock, asynchronous |
| phaseWord | output | 9 | {wrap bit, channel[4:0], bit[2:0]} of the latest capture |

## Verification
The assertions check the cycle-level rules on every cycle:
- the counter steps by one or realigns to zero;
- a capture loads the counter value from the previous cycle;
- the reading and the wrap bit stay put when nothing allows them to change;
- captures never come on back-to-back cycles.

Some behaviour only the bench scenarios can show:
- whether the wrap bit toggles at the right moments, which the bench tests with steady drift forward and backward, jumps of exactly half a frame, and a locked phase;
- how frame pulses that do not arrive every 256 bits interact with the free-running count;
- that holding the 8 kHz input high leaves the reading frozen.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Strobes from control to datapath, valid for one bit-clock cycle
  typedef struct packed {
    logic realign;  // load counter with channel 0, bit 0
    logic capture;  // store current position as the phase reading
    logic compare;  // a previous reading exists; evaluate the wrap rule
  } fpmStrobes_t;

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                framePulse,
  input  logic                refClk8k,
  output fpm_pkg::fpmStrobes_t strobes
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   edgeHist;
  logic                   havePrev;
  logic                   refRise;

  // Synchroniser chain for the asynchronous 8 kHz input
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= refClk8k;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeHist <= 1'b0;
    else       edgeHist <= syncChain[SYNC_STAGES-1];
  end

  assign refRise = syncChain[SYNC_STAGES-1] & ~edgeHist;

  // Remembers that one reading has been taken since reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        havePrev <= 1'b0;
    else if (refRise) havePrev <= 1'b1;
  end

  always_comb begin
    strobes.realign = framePulse;
    strobes.capture = refRise;
    strobes.compare = refRise & havePrev;
  end

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath #(
  parameter int CHANNELS    = 32,
  parameter int BITS_PER_CH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  fpm_pkg::fpmStrobes_t strobes,
  output logic [$clog2(CHANNELS)+$clog2(BITS_PER_CH)-1:0] curPos,
  output logic [$clog2(CHANNELS)+$clog2(BITS_PER_CH):0]   phaseWord
);

  localparam int CH_W  = $clog2(CHANNELS);
  localparam int BIT_W = $clog2(BITS_PER_CH);
  localparam int POS_W = CH_W + BIT_W;
  localparam logic [POS_W:0]   HALF     = (POS_W+1)'(1 << (POS_W - 1));
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANNELS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_CH - 1);

  logic [CH_W-1:0]  chanCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [POS_W-1:0] reading;
  logic             wrapBit;
  logic [POS_W:0]   upDist;
  logic [POS_W:0]   downDist;
  logic             crossFwd;
  logic             crossBack;

  // Bit-within-channel counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    bitCnt <= '0;
    else if (strobes.realign)     bitCnt <= '0;
    else if (bitCnt == BIT_LAST)  bitCnt <= '0;
    else                          bitCnt <= bitCnt + 1'b1;
  end

  // Channel counter, advances when the bit count rolls over
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       chanCnt <= '0;
    else if (strobes.realign)        chanCnt <= '0;
    else if (bitCnt == BIT_LAST) begin
      if (chanCnt == CH_LAST)        chanCnt <= '0;
      else                           chanCnt <= chanCnt + 1'b1;
    end
  end

  assign curPos = {chanCnt, bitCnt};

  // Distances between the new position and the held reading
  always_comb begin
    upDist    = {1'b0, curPos} - {1'b0, reading};
    downDist  = {1'b0, reading} - {1'b0, curPos};
    crossFwd  = (curPos < reading) && (downDist > HALF);
    crossBack = (curPos > reading) && (upDist > HALF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                reading <= '0;
    else if (strobes.capture) reading <= curPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wrapBit <= 1'b0;
    else if (strobes.compare && (crossFwd || crossBack))
      wrapBit <= ~wrapBit;
  end

  assign phaseWord = {wrapBit, reading};

endmodule

// File: rtl/frame_phase_meter.sv
module frame_phase_meter #(
  parameter int CHANNELS    = 32,
  parameter int BITS_PER_CH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic framePulse,
  input  logic refClk8k,
  output logic [$clog2(CHANNELS)+$clog2(BITS_PER_CH):0] phaseWord
);

  localparam int POS_W = $clog2(CHANNELS) + $clog2(BITS_PER_CH);

  fpm_pkg::fpmStrobes_t strobes;
  logic [POS_W-1:0]     curPos;
  logic                 captureStb;
  logic                 compareStb;

  fpm_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .framePulse(framePulse),
    .refClk8k  (refClk8k),
    .strobes   (strobes)
  );

  fpm_datapath #(
    .CHANNELS   (CHANNELS),
    .BITS_PER_CH(BITS_PER_CH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .curPos   (curPos),
    .phaseWord(phaseWord)
  );

  assign captureStb = strobes.capture;
  assign compareStb = strobes.compare;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             framePulse,
  input logic             captureStb,
  input logic             compareStb,
  input logic [POS_W-1:0] curPos,
  input logic [POS_W:0]   phaseWord
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  // R1: counter steps by one when no frame pulse
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !framePulse |=> curPos == $past(curPos) + ONE);

  // R2: frame pulse realigns counter to zero
  a_r2_realign: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> curPos == '0);

  // R3: a capture loads the position from the capture cycle
  a_r3_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |=> phaseWord[POS_W-1:0] == $past(curPos));

  // R3: rising edges are at least two cycles apart after synchronising
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |=> !captureStb);

  // R4: reading holds without a capture
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !captureStb |=> $stable(phaseWord[POS_W-1:0]));

  // R7: wrap bit moves only on a compare strobe
  a_r7_wrap_gated: assert property (@(posedge clk) disable iff (!rstN)
    !compareStb |=> $stable(phaseWord[POS_W]));

  // R8: reset clears the phase word
  a_r8_reset_clear: assert property (@(posedge clk)
    !rstN |-> phaseWord == '0);

endmodule

bind frame_phase_meter fpm_checker #(
  .POS_W(POS_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .framePulse(framePulse),
  .captureStb(captureStb),
  .compareStb(compareStb),
  .curPos    (curPos),
  .phaseWord (phaseWord)
);

// File: tb/frame_phase_meter_tb_top.sv
`timescale 1ns/1ps
module frame_phase_meter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       framePulse = 1'b0;
  logic       refClk8k = 1'b0;
  logic [8:0] phaseWord;

  integer checks = 0;
  integer errors = 0;

  // stimulus controls
  integer refPeriod = 256;
  integer fpPeriod  = 256;
  bit     refHold   = 1'b0;
  integer refCnt    = 0;
  integer fpCnt     = 0;

  // reference model state
  integer mPos = 0, mS1 = 0, mS2 = 0, mS3 = 0;
  integer mRead = 0, mWrap = 0, mHave = 0;

  // toggle tallies
  integer dutToggles = 0;
  integer prevDutWrap = 0;

  always #2 clk = ~clk;

  frame_phase_meter dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .framePulse(framePulse),
    .refClk8k  (refClk8k),
    .phaseWord (phaseWord)
  );

  task automatic check(input bit ok, input string tag, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, evaluated from pre-edge values
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPos = 0; mS1 = 0; mS2 = 0; mS3 = 0;
      mRead = 0; mWrap = 0; mHave = 0;
    end else begin
      if (mS2 == 1 && mS3 == 0) begin
        if (mHave == 1) begin
          if (mPos < mRead && (mRead - mPos) > 128) mWrap = 1 - mWrap;
          if (mPos > mRead && (mPos - mRead) > 128) mWrap = 1 - mWrap;
        end
        mRead = mPos;
        mHave = 1;
      end
      mPos = framePulse ? 0 : (mPos + 1) % 256;
      mS3 = mS2; mS2 = mS1; mS1 = refClk8k ? 1 : 0;
    end
  end

  // compare every cycle, then drive next inputs
  always @(negedge clk) begin
    if (rstN) begin
      check(phaseWord[7:0] == mRead[7:0], "R3 reading", phaseWord[7:0], mRead);
      check(phaseWord[8] == mWrap[0], "R5 wrap bit", phaseWord[8], mWrap);
      if (phaseWord[8] != prevDutWrap[0]) dutToggles++;
      prevDutWrap = phaseWord[8];
      refCnt = (refCnt + 1 >= refPeriod) ? 0 : refCnt + 1;
      fpCnt  = (fpCnt + 1 >= fpPeriod) ? 0 : fpCnt + 1;
      refClk8k   = refHold ? 1'b1 : (refCnt < refPeriod / 2);
      framePulse = (fpCnt == fpPeriod - 1);
    end
  end

  task automatic runFor(input integer n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [8:0] held;
    runFor(5);
    check(phaseWord == 9'd0, "R8 reset value", phaseWord, 0);
    rstN = 1'b1;

    // locked phase: first capture and steady readings never toggle
    dutToggles = 0;
    runFor(3000);
    check(phaseWord[8] == 1'b0, "R7 first capture no toggle", phaseWord[8], 0);
    check(dutToggles == 0, "R7 locked no toggle", dutToggles, 0);
    check(mHave == 1, "R3 capture seen", mHave, 1);

    // forward drift: readings grow by 3 each period
    dutToggles = 0;
    refPeriod = 259;
    runFor(259 * 100);
    check(dutToggles >= 1, "R5 forward crossing", dutToggles, 1);

    // backward drift: readings shrink by 3 each period
    dutToggles = 0;
    refPeriod = 253;
    runFor(253 * 100);
    check(dutToggles >= 1, "R6 backward crossing", dutToggles, 1);

    // exactly half a frame per reading: no toggle
    refPeriod = 384;
    runFor(384 * 2);
    dutToggles = 0;
    runFor(384 * 10);
    check(dutToggles == 0, "R7 half-frame jump", dutToggles, 0);

    // one more than half: toggles on alternate captures
    dutToggles = 0;
    refPeriod = 385;
    runFor(385 * 10);
    check(dutToggles >= 1, "R6 just over half", dutToggles, 1);

    // frame pulse every 300 bits, reference locked to it
    refPeriod = 300;
    fpPeriod  = 300;
    runFor(3000);
    check(mRead < 300 && phaseWord[7:0] == mRead[7:0], "R2 realign reading", phaseWord[7:0], mRead);
    check(mPos <= 255, "R1 counter range", mPos, 255);

    // hold the reference high: reading must freeze
    refHold = 1'b1;
    runFor(10);
    held = phaseWord;
    runFor(1000);
    check(phaseWord == held, "R4 hold without edge", phaseWord, held);
    refHold = 1'b0;
    runFor(600);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule